// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Controller

This block turns message-signalled interrupts into a single level interrupt for a host processor. Software programs a 64-bit capture address. When an inbound write arrives whose address equals that value, the low bits of the write data pick one of 256 vectors and set that vector's pending status bit. A vector whose index is 256 or more is dropped.

The vectors are split into 8 banks of 32. Each bank has an enable word, a mask word and a status word, and software reaches them through a simple word-wide register port. An inbound write can set a status bit only while that vector's enable bit is 1. The mask does not block the capture. It only hides the bit from the interrupt output. Software acknowledges vectors by writing ones to the status word. The interrupt output is high whenever any bank holds a bit that is set in status and in enable and clear in mask.

A typical interrupt handler reads each bank's status and mask words, handles the unmasked set bits, and then writes those bits back to status to clear them.

Top module: `msi_vector_ctrl`

## Requirements
- R1: After reset every enable word reads 0, every mask word reads 32'hFFFF_FFFF, every status word reads 0, both capture-address words read 0 and irq_o is 0.
- R2: The low 32 bits of the capture address are read and written at byte offset 0x820, and the high 32 bits at 0x824.
- R3: Bank n (n = 0..7) starts at byte offset 0x828 + 12*n. Its enable word is at +0, its mask word at +4 and its status word at +8. The enable and mask words read back the value last written.
- R4: An inbound write whose 64-bit address equals the capture address, and whose data value is below 256, sets status bit data[4:0] of bank data[7:5], provided that vector is enabled. The bit reads as set from the cycle after the write.
- R5: An inbound write whose address differs from the capture address in either half changes no status bit.
- R6: An inbound write with a data value of 256 or more changes no status bit, even when its low 8 bits name an enabled vector.
- R7: An inbound write to a vector whose enable bit is 0 leaves that status bit at 0.
- R8: Writing a word to a status register clears the bits where the word has ones and leaves the other bits unchanged.
- R9: irq_o is the OR, over all banks, of status AND enable AND NOT mask. A masked vector still records its status bit, and irq_o rises once the mask bit is cleared.
- R10: If an inbound write sets a bit in the same cycle that software clears that bit, the bit ends up set. A clear of another bit in that cycle still takes effect.
- R11: Register addresses whose low two bits are not 00, and addresses outside the mapped words, read as 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational from the registers |
| in_valid | input | 1 | An inbound write is present this cycle |
| in_addr | input | 64 | Address of the inbound write |
| in_data | input | 32 | Data of the inbound write (the vector index) |
| irq_o | output | 1 | Level interrupt toward the host |

## Verification
The hardest situation to create from the ports is a software clear and an inbound set landing on the same status bit in the same clock. The bench drives a status-register write and an inbound write in the same cycle, once on the same bit and once on different bits. The second hard case is a set that is recorded while the vector is masked. To reach it, the stimulus masks a bank, injects a vector there, and confirms that status is set while irq_o stays low. It then unmasks the bank and expects irq_o to rise. Out-of-range indices are chosen so that their low 8 bits alias an enabled vector whose bit is still clear, so a truncation bug would show up as a wrongly set bit.

// File: rtl/msi_pkg.sv
package msi_pkg;

    // Kind of register addressed on the software port.
    typedef enum logic [1:0] {
        RK_NONE   = 2'd0,
        RK_CAP_LO = 2'd1,
        RK_CAP_HI = 2'd2,
        RK_BANK   = 2'd3
    } reg_kind_e;

    // Word within a vector bank; the value equals the word index inside the bank.
    typedef enum logic [1:0] {
        FLD_ENABLE = 2'd0,
        FLD_MASK   = 2'd1,
        FLD_STATUS = 2'd2
    } bank_field_e;

endpackage

// File: rtl/msi_capture_match.sv
module msi_capture_match #(
    parameter int REG_W = 32,
    parameter int IDX_W = 8,
    localparam int CAP_W = 2 * REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [REG_W-1:0] wdata,
    input  logic             in_valid,
    input  logic [CAP_W-1:0] in_addr,
    input  logic [REG_W-1:0] in_data,
    output logic [CAP_W-1:0] cap_addr,
    output logic             fire,
    output logic [IDX_W-1:0] vec_idx
);

    logic [REG_W-1:0] cap_lo_q;
    logic [REG_W-1:0] cap_hi_q;
    logic             addr_eq;
    logic             idx_in_range;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_lo_q <= '0;
            cap_hi_q <= '0;
        end else begin
            if (wr_lo) cap_lo_q <= wdata;
            if (wr_hi) cap_hi_q <= wdata;
        end
    end

    assign cap_addr = {cap_hi_q, cap_lo_q};

    // Compare against the registered address only; a same-cycle rewrite
    // applies to the next inbound write.
    always_comb begin
        addr_eq      = (in_addr == cap_addr);
        idx_in_range = (in_data[REG_W-1:IDX_W] == '0);
        fire         = in_valid && addr_eq && idx_in_range;
        vec_idx      = in_data[IDX_W-1:0];
    end

endmodule

// File: rtl/msi_reg_decode.sv
module msi_reg_decode
    import msi_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int NUM_GROUPS = 8,
    parameter int GRP_W      = 3,
    parameter int CAP_LO_OFS = 'h820,
    parameter int GRP_BASE   = 'h828,
    parameter int GRP_STRIDE = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output bank_field_e       field,
    output logic [GRP_W-1:0]  grp
);

    localparam int WORD_W    = ADDR_W - 2;
    localparam int LO_WORD   = CAP_LO_OFS / 4;
    localparam int HI_WORD   = LO_WORD + 1;
    localparam int BASE_WORD = GRP_BASE / 4;
    localparam int STEP_WORD = GRP_STRIDE / 4;
    localparam int FIELDS    = 3;

    logic              aligned;
    logic [WORD_W-1:0] word;

    assign aligned = (addr[1:0] == 2'b00);
    assign word    = addr[ADDR_W-1:2];

    always_comb begin
        kind  = RK_NONE;
        field = FLD_ENABLE;
        grp   = '0;
        if (aligned) begin
            if (word == WORD_W'(LO_WORD)) begin
                kind = RK_CAP_LO;
            end else if (word == WORD_W'(HI_WORD)) begin
                kind = RK_CAP_HI;
            end else begin
                for (int g = 0; g < NUM_GROUPS; g++) begin
                    for (int f = 0; f < FIELDS; f++) begin
                        if (word == WORD_W'(BASE_WORD + g * STEP_WORD + f)) begin
                            kind  = RK_BANK;
                            grp   = GRP_W'(g);
                            field = bank_field_e'(f);
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/msi_vector_group.sv
module msi_vector_group #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_enable,
    input  logic             wr_mask,
    input  logic             wr_status,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] set_req,
    output logic [WIDTH-1:0] enable_q,
    output logic [WIDTH-1:0] mask_q,
    output logic [WIDTH-1:0] status_q,
    output logic [WIDTH-1:0] pending
);

    logic [WIDTH-1:0] set_eff;
    logic [WIDTH-1:0] clr_bits;
    logic [WIDTH-1:0] status_d;

    always_comb begin
        // Capture is gated by the enable value held before any same-cycle write.
        set_eff  = set_req & enable_q;
        clr_bits = wr_status ? wdata : '0;
        // Set is applied after the clear, so it wins on a collision.
        status_d = (status_q & ~clr_bits) | set_eff;
        pending  = status_q & enable_q & ~mask_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            mask_q   <= '1;
            status_q <= '0;
        end else begin
            if (wr_enable) enable_q <= wdata;
            if (wr_mask)   mask_q   <= wdata;
            status_q <= status_d;
        end
    end

endmodule

// File: rtl/msi_vector_ctrl.sv
module msi_vector_ctrl
    import msi_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    parameter int REG_W      = 32,
    parameter int ADDR_W     = 12,
    parameter int CAP_LO_OFS = 'h820,
    parameter int GRP_BASE   = 'h828,
    parameter int GRP_STRIDE = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic                 in_valid,
    input  logic [2*REG_W-1:0]   in_addr,
    input  logic [REG_W-1:0]     in_data,
    output logic                 irq_o
);

    localparam int NUM_VEC = NUM_GROUPS * REG_W;
    localparam int IDX_W   = $clog2(NUM_VEC);
    localparam int BIT_W   = $clog2(REG_W);
    localparam int GRP_W   = IDX_W - BIT_W;
    localparam int CAP_W   = 2 * REG_W;

    reg_kind_e        acc_kind;
    bank_field_e      acc_field;
    logic [GRP_W-1:0] acc_grp;

    logic [CAP_W-1:0] cap_addr;
    logic             fire;
    logic [IDX_W-1:0] vec_idx;
    logic [GRP_W-1:0] vec_grp;
    logic [BIT_W-1:0] vec_bit;

    logic [REG_W-1:0] en_arr   [NUM_GROUPS];
    logic [REG_W-1:0] mask_arr [NUM_GROUPS];
    logic [REG_W-1:0] stat_arr [NUM_GROUPS];
    logic [REG_W-1:0] pend_arr [NUM_GROUPS];

    logic [NUM_VEC-1:0] en_flat;
    logic [NUM_VEC-1:0] status_flat;
    logic [NUM_VEC-1:0] pend_flat;

    msi_reg_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_GROUPS(NUM_GROUPS),
        .GRP_W     (GRP_W),
        .CAP_LO_OFS(CAP_LO_OFS),
        .GRP_BASE  (GRP_BASE),
        .GRP_STRIDE(GRP_STRIDE)
    ) decode_i (
        .addr (reg_addr),
        .kind (acc_kind),
        .field(acc_field),
        .grp  (acc_grp)
    );

    msi_capture_match #(
        .REG_W(REG_W),
        .IDX_W(IDX_W)
    ) match_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo   (reg_we && (acc_kind == RK_CAP_LO)),
        .wr_hi   (reg_we && (acc_kind == RK_CAP_HI)),
        .wdata   (reg_wdata),
        .in_valid(in_valid),
        .in_addr (in_addr),
        .in_data (in_data),
        .cap_addr(cap_addr),
        .fire    (fire),
        .vec_idx (vec_idx)
    );

    assign vec_grp = vec_idx[IDX_W-1:BIT_W];
    assign vec_bit = vec_idx[BIT_W-1:0];

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
        logic             bank_hit;
        logic [REG_W-1:0] set_req;

        assign bank_hit = reg_we && (acc_kind == RK_BANK) && (acc_grp == GRP_W'(g));
        assign set_req  = (fire && (vec_grp == GRP_W'(g))) ? (REG_W'(1) << vec_bit) : '0;

        msi_vector_group #(
            .WIDTH(REG_W)
        ) group_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_enable(bank_hit && (acc_field == FLD_ENABLE)),
            .wr_mask  (bank_hit && (acc_field == FLD_MASK)),
            .wr_status(bank_hit && (acc_field == FLD_STATUS)),
            .wdata    (reg_wdata),
            .set_req  (set_req),
            .enable_q (en_arr[g]),
            .mask_q   (mask_arr[g]),
            .status_q (stat_arr[g]),
            .pending  (pend_arr[g])
        );

        assign en_flat[g*REG_W +: REG_W]     = en_arr[g];
        assign status_flat[g*REG_W +: REG_W] = stat_arr[g];
        assign pend_flat[g*REG_W +: REG_W]   = pend_arr[g];
    end

    always_comb begin
        reg_rdata = '0;
        unique case (acc_kind)
            RK_CAP_LO: reg_rdata = cap_addr[REG_W-1:0];
            RK_CAP_HI: reg_rdata = cap_addr[CAP_W-1:REG_W];
            RK_BANK: begin
                unique case (acc_field)
                    FLD_ENABLE: reg_rdata = en_arr[acc_grp];
                    FLD_MASK:   reg_rdata = mask_arr[acc_grp];
                    FLD_STATUS: reg_rdata = stat_arr[acc_grp];
                    default:    reg_rdata = '0;
                endcase
            end
            default: reg_rdata = '0;
        endcase
    end

    assign irq_o = |pend_flat;

endmodule

// File: rtl/msi_vector_ctrl_chk.sv
module msi_vector_ctrl_chk #(
    parameter int NUM_VEC = 256,
    parameter int REG_W   = 32,
    localparam int IDX_W  = $clog2(NUM_VEC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [2*REG_W-1:0] in_addr,
    input logic [REG_W-1:0]   in_data,
    input logic [2*REG_W-1:0] cap_addr,
    input logic [NUM_VEC-1:0] en_flat,
    input logic [NUM_VEC-1:0] status_flat,
    input logic               irq_o
);

    assert_set_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_addr == cap_addr) && (in_data < NUM_VEC) && en_flat[in_data[IDX_W-1:0]])
        |=> status_flat[$past(in_data[IDX_W-1:0])]);

    assert_mismatch_no_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_addr != cap_addr) |=> ((status_flat & ~$past(status_flat)) == '0));

    assert_oversize_no_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data >= NUM_VEC) |=> ((status_flat & ~$past(status_flat)) == '0));

    assert_disabled_stays_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_data < NUM_VEC) && !en_flat[in_data[IDX_W-1:0]]
                  && !status_flat[in_data[IDX_W-1:0]])
        |=> !status_flat[$past(in_data[IDX_W-1:0])]);

    assert_irq_needs_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((status_flat & en_flat) != '0));

endmodule

bind msi_vector_ctrl msi_vector_ctrl_chk #(
    .NUM_VEC(NUM_GROUPS * REG_W),
    .REG_W  (REG_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_addr    (in_addr),
    .in_data    (in_data),
    .cap_addr   (cap_addr),
    .en_flat    (en_flat),
    .status_flat(status_flat),
    .irq_o      (irq_o)
);

// File: tb/msi_vector_ctrl_tb_top.sv
`timescale 1ns/1ps
module msi_vector_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        in_valid;
    logic [63:0] in_addr;
    logic [31:0] in_data;
    logic        irq_o;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done  = 1'b0;

    localparam logic [63:0] CAP = 64'h0000_00A5_FEE0_1000;

    always #4 clk = ~clk;

    msi_vector_ctrl dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .in_valid (in_valid),
        .in_addr  (in_addr),
        .in_data  (in_data),
        .irq_o    (irq_o)
    );

    // Behavioural reference model
    logic [31:0] m_en   [8];
    logic [31:0] m_mask [8];
    logic [31:0] m_stat [8];
    logic [63:0] m_cap;

    function automatic int bank_of(input int a);
        if (a >= 'h828 && a < 'h828 + 96 && (a % 4) == 0) return (a - 'h828) / 12;
        return -1;
    endfunction

    function automatic int word_of(input int a);
        return ((a - 'h828) % 12) / 4;
    endfunction

    function automatic logic [31:0] m_read(input int a);
        int b;
        b = bank_of(a);
        if (a == 'h820) return m_cap[31:0];
        if (a == 'h824) return m_cap[63:32];
        if (b < 0) return 32'h0;
        case (word_of(a))
            0: return m_en[b];
            1: return m_mask[b];
            default: return m_stat[b];
        endcase
    endfunction

    function automatic logic m_irq();
        logic r = 1'b0;
        for (int g = 0; g < 8; g++) r |= |(m_stat[g] & m_en[g] & ~m_mask[g]);
        return r;
    endfunction

    always @(posedge clk) begin : model
        logic [31:0] setv [8];
        int a, b, v;
        if (!rst_n) begin
            for (int g = 0; g < 8; g++) begin
                m_en[g] = '0; m_mask[g] = '1; m_stat[g] = '0;
            end
            m_cap = '0;
        end else begin
            for (int g = 0; g < 8; g++) setv[g] = '0;
            if (in_valid && in_addr == m_cap && in_data < 256) begin
                v = int'(in_data);
                setv[v / 32][v % 32] = m_en[v / 32][v % 32];
            end
            if (reg_we) begin
                a = int'(reg_addr);
                b = bank_of(a);
                if (a == 'h820) m_cap[31:0] = reg_wdata;
                else if (a == 'h824) m_cap[63:32] = reg_wdata;
                else if (b >= 0) begin
                    case (word_of(a))
                        0: m_en[b] = reg_wdata;
                        1: m_mask[b] = reg_wdata;
                        default: m_stat[b] = m_stat[b] & ~reg_wdata;
                    endcase
                end
            end
            for (int g = 0; g < 8; g++) m_stat[g] = m_stat[g] | setv[g];
        end
    end

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // irq_o compared against the model on every clock
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) chk("R9 irq per cycle", {63'b0, irq_o}, {63'b0, m_irq()});
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            summary();
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic inj(input logic [63:0] a, input logic [31:0] d);
        in_valid = 1'b1; in_addr = a; in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic both(input logic [11:0] ra, input logic [31:0] rd, input logic [31:0] vec);
        reg_we = 1'b1; reg_addr = ra; reg_wdata = rd;
        in_valid = 1'b1; in_addr = CAP; in_data = vec;
        @(negedge clk);
        reg_we = 1'b0; in_valid = 1'b0;
    endtask

    task automatic rd_lit(input string tag, input logic [11:0] a, input logic [31:0] exp);
        reg_addr = a; #1;
        chk(tag, {32'b0, reg_rdata}, {32'b0, exp});
    endtask

    task automatic rd_m(input string tag, input logic [11:0] a);
        reg_addr = a; #1;
        chk(tag, {32'b0, reg_rdata}, {32'b0, m_read(int'(a))});
    endtask

    function automatic logic [11:0] ra(input int g, input int w);
        return 12'('h828 + 12 * g + 4 * w);
    endfunction

    initial begin
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        in_valid = 1'b0; in_addr = '0; in_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_lit("R1 cap lo", 12'h820, 32'h0);
        rd_lit("R1 cap hi", 12'h824, 32'h0);
        for (int g = 0; g < 8; g++) begin
            rd_lit("R1 enable", ra(g, 0), 32'h0);
            rd_lit("R1 mask", ra(g, 1), 32'hFFFF_FFFF);
            rd_lit("R1 status", ra(g, 2), 32'h0);
        end
        chk("R1 irq", {63'b0, irq_o}, 64'h0);

        // R2 capture address
        wr(12'h820, CAP[31:0]);
        wr(12'h824, CAP[63:32]);
        rd_lit("R2 cap lo", 12'h820, CAP[31:0]);
        rd_lit("R2 cap hi", 12'h824, CAP[63:32]);

        // R3 bank layout
        for (int g = 0; g < 8; g++) begin
            wr(ra(g, 0), (32'h1111_1111 * g) ^ 32'h8000_0001);
            wr(ra(g, 1), ~(32'h0101_0101 << g));
        end
        for (int g = 0; g < 8; g++) begin
            rd_lit("R3 enable", ra(g, 0), (32'h1111_1111 * g) ^ 32'h8000_0001);
            rd_lit("R3 mask", ra(g, 1), ~(32'h0101_0101 << g));
        end
        for (int g = 0; g < 8; g++) begin
            wr(ra(g, 0), 32'hFFFF_FFFF);
            wr(ra(g, 1), 32'h0);
        end

        // R4 capture of several vectors
        inj(CAP, 0); inj(CAP, 31); inj(CAP, 32); inj(CAP, 100); inj(CAP, 255);
        rd_lit("R4 bank0", ra(0, 2), 32'h8000_0001);
        rd_lit("R4 bank1", ra(1, 2), 32'h0000_0001);
        rd_lit("R4 bank3", ra(3, 2), 32'h0000_0010);
        rd_lit("R4 bank7", ra(7, 2), 32'h8000_0000);
        chk("R9 irq with pending", {63'b0, irq_o}, 64'h1);

        // R5 address mismatch in low and high halves
        inj(CAP ^ 64'h1, 7);
        inj(CAP ^ (64'h1 << 40), 8);
        rd_lit("R5 bank0", ra(0, 2), 32'h8000_0001);

        // R6 oversize index aliasing bit 2 of bank 0
        inj(CAP, 32'h0000_0102);
        inj(CAP, 32'h8000_0002);
        rd_lit("R6 bank0", ra(0, 2), 32'h8000_0001);

        // R7 disabled vector 67 (bank 2 bit 3)
        wr(ra(2, 0), 32'hFFFF_FFF7);
        inj(CAP, 67);
        rd_lit("R7 bank2", ra(2, 2), 32'h0);

        // R8 write-one-to-clear
        wr(ra(0, 2), 32'h8000_0000);
        rd_lit("R8 partial clear", ra(0, 2), 32'h0000_0001);
        wr(ra(0, 2), 32'h0);
        rd_lit("R8 zero write", ra(0, 2), 32'h0000_0001);

        // R9 masked capture then unmask
        for (int g = 0; g < 8; g++) wr(ra(g, 2), 32'hFFFF_FFFF);
        chk("R9 all clear", {63'b0, irq_o}, 64'h0);
        wr(ra(1, 1), 32'hFFFF_FFFF);
        inj(CAP, 40);
        rd_lit("R9 masked status", ra(1, 2), 32'h0000_0100);
        chk("R9 masked irq low", {63'b0, irq_o}, 64'h0);
        wr(ra(1, 1), 32'h0);
        chk("R9 unmasked irq high", {63'b0, irq_o}, 64'h1);

        // R10 same-cycle set and clear
        inj(CAP, 5);
        both(ra(0, 2), 32'h0000_0020, 5);
        rd_lit("R10 set wins", ra(0, 2), 32'h0000_0020);
        both(ra(0, 2), 32'h0000_0020, 6);
        rd_lit("R10 other bit", ra(0, 2), 32'h0000_0040);

        // R11 unmapped and misaligned
        wr(12'h888, 32'hFFFF_FFFF);
        wr(12'h81C, 32'hFFFF_FFFF);
        wr(12'h829, 32'h0);
        wr(12'h82A, 32'hFFFF_FFFF);
        rd_lit("R11 read 0x888", 12'h888, 32'h0);
        rd_lit("R11 read 0x81C", 12'h81C, 32'h0);
        rd_lit("R11 read misaligned", 12'h829, 32'h0);
        rd_lit("R11 enable kept", ra(0, 0), 32'hFFFF_FFFF);
        rd_lit("R11 mask kept", ra(0, 1), 32'h0);
        for (int g = 0; g < 8; g++) begin
            rd_m("R11 enable model", ra(g, 0));
            rd_m("R11 mask model", ra(g, 1));
            rd_m("R11 status model", ra(g, 2));
        end

        @(negedge clk);
        done = 1'b1;
        summary();
    end

endmodule